// File: doc/BRIEF.md
# Associative Address Translator with Access Checking

This block turns a 32-bit virtual address into a physical address for a read or a write. It uses a fully associative table of page descriptors. Each descriptor carries a virtual page number, a physical page number, an 8-bit address-space tag, a 2-bit page-size code, and the flags valid, shared, dirty, cacheable and a 2-bit permission field. Some high address windows skip the table entirely. When the translation switch is off, the address is folded into a 29-bit space. Otherwise every valid descriptor is compared against the request in the same cycle. The block reports the physical address, or a fault code that tells the requester which exception to raise.

A request is presented for one cycle on `req_valid`, and its result is registered and shown one cycle later. Descriptors are loaded through a simple indexed write port. The block keeps a 6-bit victim pointer that advances on every table search. Software loading a new descriptor can use that pointer as the slot to overwrite. On faults, the offending address and its page number are captured for the handler.

Top module: `addr_xlate`

## Requirements
- R1: After synchronous reset, `rsp_valid` is 0, `victim_idx`, `fault_vpn` and `fault_vaddr` are 0, and every descriptor is invalid, so the first table search misses.
- R2: Each cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the next cycle, and no response appears otherwise. On a fault, `rsp_fault` is 1, `rsp_paddr` is 0 and `rsp_cacheable` is 0. Without a fault, `rsp_code` is 0.
- R3: The size code selects the page size: 0 gives 1 KiB, 1 gives 4 KiB, 2 gives 64 KiB and 3 gives 1 MiB. A descriptor covers the addresses of its page number (in 1 KiB units) rounded down to the page size. The physical address is the physical page number (in 1 KiB units) rounded down to the page size, combined with the address offset inside the page.
- R4: Invalid descriptors never match. The tag is compared with `cfg_asid` unless the descriptor is shared, or unless both `cfg_single_vs` and `cfg_priv` are 1.
- R5: Two or more matching descriptors give code 0x140, and this fault leaves `fault_vpn` unchanged.
- R6: When no descriptor matches, a read gives code 0x040 and a write gives code 0x060.
- R7: Checks on a single hit apply in this order. First, in user mode (`cfg_priv`=0), permission bit 1 clear gives 0x0A0 on a read and 0x0C0 on a write. Next, a write with permission bit 0 clear gives 0x0C0. Finally, a write with the dirty bit clear gives 0x080.
- R8: Addresses 0x80000000 to 0xBFFFFFFF bypass the table with bits 31:29 cleared, and addresses from 0xE0000000 upward pass through unchanged. In user mode, any address at or above 0x80000000 faults with 0x0E0 on a read or 0x100 on a write, except 0xE0000000 to 0xE3FFFFFF. The window 0xC0000000 to 0xDFFFFFFF is translated.
- R9: With `cfg_xlate_en`=0, an address below 0x80000000 or in 0xC0000000 to 0xDFFFFFFF maps to itself with bits 31:29 cleared, never faults and does not search the table.
- R10: `victim_idx` advances by one on each table search. It wraps to 0 when the incremented value exceeds a nonzero `cfg_wrap_at`, or when it exceeds `NUM_ENT`-1. It holds when no search occurs.
- R11: Every fault captures the full virtual address into `fault_vaddr`. Every fault except 0x140 captures address bits 31:10 into `fault_vpn`.
- R12: A successful table translation reports the descriptor's cacheable flag on `rsp_cacheable`. Bypass and untranslated results report 0.
- R13: A descriptor written through the write port is used from the next cycle on. A search in the same cycle as the write sees the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_vaddr | input | 32 | Virtual address |
| cfg_xlate_en | input | 1 | Translation switch |
| cfg_priv | input | 1 | Privileged mode |
| cfg_single_vs | input | 1 | Single virtual space mode (tag check off when privileged) |
| cfg_asid | input | 8 | Current address-space tag |
| cfg_wrap_at | input | CTR_W | Victim pointer wrap boundary, 0 = none |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | IDX_W | Descriptor slot written |
| wr_vpn | input | 22 | Virtual page number, 1 KiB units |
| wr_ppn | input | 22 | Physical page number, 1 KiB units |
| wr_asid | input | 8 | Address-space tag |
| wr_size | input | 2 | Page-size code |
| wr_valid | input | 1 | Valid flag |
| wr_shared | input | 1 | Shared flag (tag ignored) |
| wr_dirty | input | 1 | Dirty flag |
| wr_cacheable | input | 1 | Cacheable flag |
| wr_prot | input | 2 | Permission: bit 1 user access, bit 0 write allowed |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 12 | Fault code, 0 when none |
| rsp_paddr | output | 32 | Physical address |
| rsp_cacheable | output | 1 | Cacheable flag of the result |
| fault_vpn | output | 22 | Captured faulting page number |
| fault_vaddr | output | 32 | Captured faulting address |
| victim_idx | output | CTR_W | Replacement victim pointer |

## Verification
A corrupted descriptor flag or page field shows at the ports on the very next request that touches that page. It appears as a wrong fault code, a wrong physical address or a wrong cacheable bit, one cycle after that request. A victim pointer that steps wrongly, or wraps at the wrong bound, differs from the model after one search, so it is compared after every request. The same comparison is made for the capture registers. A capture made on a multi-hit, or missed on another fault, shows on the next fault-carrying request.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int VA_W   = 32;
  localparam int OFS_W  = 10;
  localparam int VPN_W  = VA_W - OFS_W;
  localparam int PPN_W  = 22;
  localparam int ASID_W = 8;
  localparam int CODE_W = 12;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic [1:0]        szc;
    logic              vld;
    logic              shr;
    logic              dty;
    logic              cch;
    logic [1:0]        prm;
  } xent_t;

  localparam logic [CODE_W-1:0] FC_NONE     = 12'h000;
  localparam logic [CODE_W-1:0] FC_RD_MISS  = 12'h040;
  localparam logic [CODE_W-1:0] FC_WR_MISS  = 12'h060;
  localparam logic [CODE_W-1:0] FC_FIRST_WR = 12'h080;
  localparam logic [CODE_W-1:0] FC_RD_PROT  = 12'h0A0;
  localparam logic [CODE_W-1:0] FC_WR_PROT  = 12'h0C0;
  localparam logic [CODE_W-1:0] FC_RD_AERR  = 12'h0E0;
  localparam logic [CODE_W-1:0] FC_WR_AERR  = 12'h100;
  localparam logic [CODE_W-1:0] FC_MULTI    = 12'h140;

  // Page-number bits that lie inside the page for a given size code.
  function automatic logic [VPN_W-1:0] span_mask(input logic [1:0] szc);
    case (szc)
      2'b00:   span_mask = VPN_W'(0);
      2'b01:   span_mask = VPN_W'(22'h3);
      2'b10:   span_mask = VPN_W'(22'h3F);
      default: span_mask = VPN_W'(22'h3FF);
    endcase
  endfunction

endpackage

// File: rtl/xlate_store.sv
module xlate_store
  import xlate_pkg::*;
#(
  parameter int NUM_ENT = 64,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  xent_t            wr_ent,
  output xent_t            ents [NUM_ENT]
);

  // Only the valid flags are reset; payload bits are don't-care until written.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENT; i++) begin
      if (rst) begin
        ents[i].vld <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        ents[i] <= wr_ent;
      end
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ents[$past(wr_idx)] == $past(wr_ent)); // R13

endmodule

// File: rtl/xlate_match.sv
module xlate_match
  import xlate_pkg::*;
#(
  parameter int NUM_ENT = 64
) (
  input  xent_t             ents [NUM_ENT],
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  input  logic              asid_chk,
  output logic              hit_any,
  output logic              hit_multi,
  output logic [PPN_W-1:0]  hit_frame,
  output logic [1:0]        hit_prm,
  output logic              hit_dty,
  output logic              hit_cch
);

  logic [NUM_ENT-1:0] hits;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    logic [VPN_W-1:0] keep;
    logic             tag_ok;
    assign keep   = ~span_mask(ents[g].szc);
    assign tag_ok = ents[g].shr || !asid_chk || (ents[g].asid == q_asid);
    assign hits[g] = ents[g].vld && tag_ok && (((ents[g].vpn ^ q_vpn) & keep) == '0);
  end

  assign hit_any   = |hits;
  // Clearing the lowest set bit leaves something only when two or more are set.
  assign hit_multi = |(hits & (hits - NUM_ENT'(1)));

  always_comb begin
    hit_frame = '0;
    hit_prm   = '0;
    hit_dty   = 1'b0;
    hit_cch   = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (hits[i]) begin
        hit_frame = hit_frame | ((ents[i].ppn & ~PPN_W'(span_mask(ents[i].szc)))
                               | (PPN_W'(q_vpn) & PPN_W'(span_mask(ents[i].szc))));
        hit_prm   = hit_prm | ents[i].prm;
        hit_dty   = hit_dty | ents[i].dty;
        hit_cch   = hit_cch | ents[i].cch;
      end
    end
  end

endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
  parameter int NUM_ENT = 64,
  parameter int CTR_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CTR_W-1:0] limit,
  output logic [CTR_W-1:0] ptr
);

  localparam logic [CTR_W:0] LAST = (CTR_W+1)'(NUM_ENT - 1);

  logic [CTR_W:0] nxt;
  logic           wrap;

  assign nxt  = {1'b0, ptr} + (CTR_W+1)'(1);
  assign wrap = ((limit != '0) && (nxt > {1'b0, limit})) || (nxt > LAST);

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (tick) ptr <= wrap ? '0 : nxt[CTR_W-1:0];
  end

  AST_VICTIM_RANGE: assert property (@(posedge clk) disable iff (rst)
    {1'b0, ptr} <= LAST); // R10
  AST_VICTIM_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> (ptr == $past(ptr) + CTR_W'(1)) || (ptr == '0)); // R10
  AST_VICTIM_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ptr)); // R10

endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import xlate_pkg::*;
#(
  parameter int NUM_ENT = 64,
  parameter int CTR_W   = 6,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [31:0]       req_vaddr,
  input  logic              cfg_xlate_en,
  input  logic              cfg_priv,
  input  logic              cfg_single_vs,
  input  logic [7:0]        cfg_asid,
  input  logic [CTR_W-1:0]  cfg_wrap_at,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [21:0]       wr_vpn,
  input  logic [21:0]       wr_ppn,
  input  logic [7:0]        wr_asid,
  input  logic [1:0]        wr_size,
  input  logic              wr_valid,
  input  logic              wr_shared,
  input  logic              wr_dirty,
  input  logic              wr_cacheable,
  input  logic [1:0]        wr_prot,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [11:0]       rsp_code,
  output logic [31:0]       rsp_paddr,
  output logic              rsp_cacheable,
  output logic [21:0]       fault_vpn,
  output logic [31:0]       fault_vaddr,
  output logic [CTR_W-1:0]  victim_idx
);

  xent_t ents [NUM_ENT];
  xent_t wr_ent;

  assign wr_ent = '{vpn: wr_vpn, ppn: wr_ppn, asid: wr_asid, szc: wr_size,
                    vld: wr_valid, shr: wr_shared, dty: wr_dirty,
                    cch: wr_cacheable, prm: wr_prot};

  xlate_store #(.NUM_ENT(NUM_ENT)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_ent(wr_ent), .ents(ents)
  );

  // Address classification
  logic [2:0] region;
  logic       in_fixed, win_open, addr_err, use_tbl, asid_chk;

  assign region   = req_vaddr[31:29];
  assign in_fixed = (region == 3'b100) || (region == 3'b101) || (region == 3'b111);
  assign win_open = (req_vaddr[31:26] == 6'b111000);
  assign addr_err = in_fixed && !cfg_priv && !win_open;
  assign use_tbl  = !in_fixed && cfg_xlate_en;
  assign asid_chk = !(cfg_single_vs && cfg_priv);

  logic             hit_any, hit_multi, hit_dty, hit_cch;
  logic [PPN_W-1:0] hit_frame;
  logic [1:0]       hit_prm;

  xlate_match #(.NUM_ENT(NUM_ENT)) u_match (
    .ents(ents), .q_vpn(req_vaddr[31:OFS_W]), .q_asid(cfg_asid),
    .asid_chk(asid_chk), .hit_any(hit_any), .hit_multi(hit_multi),
    .hit_frame(hit_frame), .hit_prm(hit_prm), .hit_dty(hit_dty),
    .hit_cch(hit_cch)
  );

  xlate_victim #(.NUM_ENT(NUM_ENT), .CTR_W(CTR_W)) u_victim (
    .clk(clk), .rst(rst), .tick(req_valid && use_tbl),
    .limit(cfg_wrap_at), .ptr(victim_idx)
  );

  // Result selection, fixed priority
  logic [CODE_W-1:0] n_code;
  logic [31:0]       n_pa;
  logic              n_cch;

  always_comb begin
    n_code = FC_NONE;
    n_pa   = '0;
    n_cch  = 1'b0;
    if (in_fixed) begin
      if (addr_err)             n_code = req_write ? FC_WR_AERR : FC_RD_AERR;
      else if (region == 3'b111) n_pa  = req_vaddr;
      else                      n_pa   = {3'b000, req_vaddr[28:0]};
    end else if (!cfg_xlate_en) begin
      n_pa = {3'b000, req_vaddr[28:0]};
    end else if (hit_multi) begin
      n_code = FC_MULTI;
    end else if (!hit_any) begin
      n_code = req_write ? FC_WR_MISS : FC_RD_MISS;
    end else if (!cfg_priv && !hit_prm[1]) begin
      n_code = req_write ? FC_WR_PROT : FC_RD_PROT;
    end else if (req_write && !hit_prm[0]) begin
      n_code = FC_WR_PROT;
    end else if (req_write && !hit_dty) begin
      n_code = FC_FIRST_WR;
    end else begin
      n_pa  = 32'({hit_frame, req_vaddr[OFS_W-1:0]});
      n_cch = hit_cch;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_code      <= '0;
      rsp_paddr     <= '0;
      rsp_cacheable <= 1'b0;
      fault_vpn     <= '0;
      fault_vaddr   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault     <= (n_code != FC_NONE);
        rsp_code      <= n_code;
        rsp_paddr     <= n_pa;
        rsp_cacheable <= n_cch;
        if (n_code != FC_NONE)                         fault_vaddr <= req_vaddr;
        if (n_code != FC_NONE && n_code != FC_MULTI)   fault_vpn   <= req_vaddr[31:OFS_W];
      end
    end
  end

  AST_FAULT_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> fault_vaddr == $past(req_vaddr)); // R11
  AST_MULTI_KEEPS_VPN: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_code == FC_MULTI |-> $stable(fault_vpn)); // R5
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0])); // R3
  AST_FAULT_BLANKS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_paddr == '0 && !rsp_cacheable); // R2
  AST_OFF_NEVER_FAULTS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !$past(cfg_xlate_en) && !$past(req_vaddr[31]) |-> !rsp_fault); // R9

endmodule

// File: tb/sim_addr_xlate.sv
module sim_addr_xlate;
  import xlate_pkg::*;

  localparam int NE = 64;
  localparam int CW = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          req_valid, req_write;
  logic [31:0]   req_vaddr;
  logic          cfg_xlate_en, cfg_priv, cfg_single_vs;
  logic [7:0]    cfg_asid;
  logic [CW-1:0] cfg_wrap_at;
  logic          wr_en;
  logic [5:0]    wr_idx;
  logic [21:0]   wr_vpn, wr_ppn;
  logic [7:0]    wr_asid;
  logic [1:0]    wr_size, wr_prot;
  logic          wr_valid, wr_shared, wr_dirty, wr_cacheable;
  logic          rsp_valid, rsp_fault, rsp_cacheable;
  logic [11:0]   rsp_code;
  logic [31:0]   rsp_paddr, fault_vaddr;
  logic [21:0]   fault_vpn;
  logic [CW-1:0] victim_idx;

  addr_xlate #(.NUM_ENT(NE), .CTR_W(CW)) u0 (.*);

  typedef struct packed {
    logic        flt;
    logic [11:0] code;
    logic [31:0] pa;
    logic        cc;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];
  int    nchk = 0;
  int    nfail = 0;
  logic [CW-1:0] vic_m = '0;
  logic [21:0]   fv_m  = '0;
  logic [31:0]   fa_m  = '0;

  // Monitor: pops one expected item per response
  always @(negedge clk) begin : mon
    exp_t  e;
    string t;
    if (!rst && rsp_valid) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R2: unexpected response, actual code %h, expected no response", rsp_code);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_fault, rsp_code, rsp_paddr, rsp_cacheable} !== e) begin
          nfail++;
          $display("FAIL %s: actual fault=%0b code=%h pa=%h c=%0b, expected fault=%0b code=%h pa=%h c=%0b",
                   t, rsp_fault, rsp_code, rsp_paddr, rsp_cacheable, e.flt, e.code, e.pa, e.cc);
        end
      end
    end
  end

  task automatic chk32(input string tg, input logic [31:0] act, input logic [31:0] exv);
    nchk++;
    if (act !== exv) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tg, act, exv);
    end
  endtask

  function automatic logic [CW-1:0] vnext(input logic [CW-1:0] v, input logic [CW-1:0] lim);
    logic [CW:0] n;
    n = {1'b0, v} + 1;
    if ((lim != 0 && n > {1'b0, lim}) || n > (NE - 1)) return '0;
    return n[CW-1:0];
  endfunction

  task automatic stage(input int idx, input logic [21:0] vpn, input logic [21:0] ppn,
                       input logic [7:0] asid, input logic [1:0] sz, input logic v,
                       input logic sh, input logic d, input logic c, input logic [1:0] pr);
    wr_idx = idx[5:0]; wr_vpn = vpn; wr_ppn = ppn; wr_asid = asid; wr_size = sz;
    wr_valid = v; wr_shared = sh; wr_dirty = d; wr_cacheable = c; wr_prot = pr;
    wr_en = 1'b1;
  endtask

  task automatic put(input int idx, input logic [21:0] vpn, input logic [21:0] ppn,
                     input logic [7:0] asid, input logic [1:0] sz, input logic v,
                     input logic sh, input logic d, input logic c, input logic [1:0] pr);
    stage(idx, vpn, ppn, asid, sz, v, sh, d, c, pr);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: applies one request, pushes its expected result, checks side state
  task automatic look(input logic [31:0] va, input logic w, input logic [11:0] code,
                      input logic [31:0] pa, input logic cc, input string tg);
    exp_t e;
    logic tabl;
    e.flt = (code != 12'h0); e.code = code; e.pa = pa; e.cc = cc;
    exp_q.push_back(e);
    tag_q.push_back(tg);
    req_vaddr = va; req_write = w; req_valid = 1'b1;
    tabl = cfg_xlate_en && (va[31:30] != 2'b10) && (va[31:29] != 3'b111);
    if (tabl) vic_m = vnext(vic_m, cfg_wrap_at);
    if (code != 12'h0) begin
      fa_m = va;
      if (code != 12'h140) fv_m = va[31:10];
    end
    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b0;
    chk32({tg, " victim R10"}, 32'(victim_idx), 32'(vic_m));
    chk32({tg, " fault_vaddr R11"}, fault_vaddr, fa_m);
    chk32({tg, " fault_vpn R11"}, 32'(fault_vpn), 32'(fv_m));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R2: watchdog expired, actual still running, expected finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 0; req_write = 0; req_vaddr = '0;
    cfg_xlate_en = 1; cfg_priv = 0; cfg_single_vs = 0; cfg_asid = 8'h12; cfg_wrap_at = '0;
    wr_en = 0; wr_idx = '0; wr_vpn = '0; wr_ppn = '0; wr_asid = '0; wr_size = '0;
    wr_valid = 0; wr_shared = 0; wr_dirty = 0; wr_cacheable = 0; wr_prot = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk32("R1 rsp_valid", 32'(rsp_valid), 0);
    chk32("R1 victim_idx", 32'(victim_idx), 0);
    chk32("R1 fault_vpn", 32'(fault_vpn), 0);
    chk32("R1 fault_vaddr", fault_vaddr, 0);
    look(32'h0000_1000, 0, 12'h040, 0, 0, "R1 empty table miss");

    // R3 / R12 page sizes and address composition
    put(0, 22'h00004, 22'h00100, 8'h12, 2'b00, 1, 0, 1, 1, 2'b11);
    look(32'h0000_11A4, 0, 0, 32'h0004_01A4, 1, "R3 1K page, R12 cacheable");
    look(32'h0000_13FF, 0, 0, 32'h0004_03FF, 1, "R3 1K last byte");
    look(32'h0000_1400, 0, 12'h040, 0, 0, "R3 1K next page misses");
    put(1, 22'h00009, 22'h00203, 8'h12, 2'b01, 1, 0, 1, 0, 2'b11);
    look(32'h0000_2ABC, 0, 0, 32'h0008_0ABC, 0, "R3 4K page, R12 not cacheable");
    look(32'h0000_2000, 0, 0, 32'h0008_0000, 0, "R3 4K rounded down");
    put(2, 22'h00045, 22'h001C5, 8'h12, 2'b10, 1, 0, 1, 1, 2'b11);
    look(32'h0001_BEEF, 0, 0, 32'h0007_BEEF, 1, "R3 64K page");

    // R4 tag filtering
    put(3, 22'h01234, 22'h00ABC, 8'h77, 2'b11, 1, 1, 1, 0, 2'b11);
    look(32'h0045_6789, 0, 0, 32'h0025_6789, 0, "R4 shared 1M page ignores tag");
    put(4, 22'h00C00, 22'h00111, 8'h55, 2'b00, 1, 0, 1, 0, 2'b11);
    look(32'h0030_0010, 0, 12'h040, 0, 0, "R4 tag mismatch misses");
    cfg_single_vs = 1; cfg_priv = 1;
    look(32'h0030_0010, 0, 0, 32'h0004_4410, 0, "R4 single space privileged skips tag");
    cfg_priv = 0;
    look(32'h0030_0010, 0, 12'h040, 0, 0, "R4 single space user still checks tag");
    cfg_single_vs = 0;
    put(5, 22'h00D00, 22'h00222, 8'h12, 2'b00, 0, 0, 1, 0, 2'b11);
    look(32'h0034_0000, 0, 12'h040, 0, 0, "R4 invalid never matches");

    // R5 multiple hits
    put(6, 22'h00E00, 22'h00301, 8'h12, 2'b00, 1, 0, 1, 0, 2'b11);
    put(7, 22'h00E00, 22'h00302, 8'h12, 2'b00, 1, 1, 1, 0, 2'b11);
    look(32'h0038_0004, 0, 12'h140, 0, 0, "R5 multi hit");

    // R6 write miss
    look(32'h0050_0000, 1, 12'h060, 0, 0, "R6 write miss");

    // R7 permission ordering
    put(8, 22'h01800, 22'h00400, 8'h12, 2'b00, 1, 0, 0, 0, 2'b01);
    look(32'h0060_0000, 0, 12'h0A0, 0, 0, "R7 user read no access");
    look(32'h0060_0000, 1, 12'h0C0, 0, 0, "R7 user write no access beats dirty");
    cfg_priv = 1;
    look(32'h0060_0000, 0, 0, 32'h0010_0000, 0, "R7 privileged read allowed");
    look(32'h0060_0000, 1, 12'h080, 0, 0, "R7 privileged write clean page");
    cfg_priv = 0;
    put(9, 22'h01801, 22'h00401, 8'h12, 2'b00, 1, 0, 1, 0, 2'b10);
    look(32'h0060_0404, 0, 0, 32'h0010_0404, 0, "R7 user read of read-only page");
    look(32'h0060_0404, 1, 12'h0C0, 0, 0, "R7 write to read-only page");
    put(10, 22'h01802, 22'h00402, 8'h12, 2'b00, 1, 0, 0, 0, 2'b11);
    look(32'h0060_0808, 1, 12'h080, 0, 0, "R7 write to clean page");
    look(32'h0060_0808, 0, 0, 32'h0010_0808, 0, "R7 read of clean page");
    put(11, 22'h01803, 22'h00403, 8'h12, 2'b00, 1, 0, 1, 1, 2'b11);
    look(32'h0060_0C00, 1, 0, 32'h0010_0C00, 1, "R7 write to dirty writable page");

    // R8 fixed windows
    look(32'h8000_1234, 0, 12'h0E0, 0, 0, "R8 user read low bypass");
    look(32'hA000_0000, 1, 12'h100, 0, 0, "R8 user write low bypass");
    look(32'hBFFF_FFFF, 0, 12'h0E0, 0, 0, "R8 user read top of bypass");
    look(32'hE000_1000, 0, 0, 32'hE000_1000, 0, "R8 user open window read");
    look(32'hE3FF_FFFC, 1, 0, 32'hE3FF_FFFC, 0, "R8 user open window top write");
    look(32'hE400_0000, 0, 12'h0E0, 0, 0, "R8 user past open window");
    look(32'hC000_0000, 0, 12'h040, 0, 0, "R8 translated high window");
    cfg_priv = 1;
    look(32'hA123_4567, 0, 0, 32'h0123_4567, 0, "R8 privileged bypass strip");
    look(32'h9FFF_FFFF, 0, 0, 32'h1FFF_FFFF, 0, "R8 privileged bypass strip top");
    look(32'hFF00_0010, 1, 0, 32'hFF00_0010, 0, "R8 privileged pass through");
    look(32'hE400_0000, 0, 0, 32'hE400_0000, 0, "R8 privileged pass through mid");
    cfg_priv = 0;

    // R9 translation off
    cfg_xlate_en = 0;
    look(32'h4000_1234, 0, 0, 32'h0000_1234, 0, "R9 off read");
    look(32'h7FFF_FFFC, 1, 0, 32'h1FFF_FFFC, 0, "R9 off write");
    look(32'h0060_0000, 1, 0, 32'h0060_0000, 0, "R9 off ignores protection");
    cfg_xlate_en = 1;

    // R13 write and search in the same cycle
    stage(12, 22'h02000, 22'h00500, 8'h12, 2'b00, 1, 0, 1, 0, 2'b11);
    look(32'h0080_0020, 0, 12'h040, 0, 0, "R13 same cycle sees old contents");
    look(32'h0080_0020, 0, 0, 32'h0014_0020, 0, "R13 next cycle sees new entry");

    // R2 idle cycle has no response
    @(negedge clk);
    chk32("R2 idle no response", 32'(rsp_valid), 0);

    // R10 victim pointer with a boundary, then full-range wrap
    cfg_wrap_at = 6'd5;
    for (int i = 0; i < 8; i++)
      look(32'h0000_1000, 0, 0, 32'h0004_0000, 1, "R10 bounded walk");
    cfg_wrap_at = 6'd0;
    for (int i = 0; i < 66; i++)
      look(32'h0070_0000, 0, 12'h040, 0, 0, "R10 full wrap");

    repeat (2) @(negedge clk);
    chk32("R2 all responses seen", 32'(exp_q.size()), 0);
    summary();
    $finish;
  end

endmodule